// File: doc/BRIEF.md
# Breathing LED PWM Generator

This block drives one PWM line whose duty ramps step by step between a low bound and a high bound and then back again. On a LED this looks like slow breathing. A PWM period is a programmable number of ticks of a 16 MHz enable strobe. Each duty value is held for a programmable number of whole periods before the ramp moves on by one tick of duty. The line rests at a selectable idle level whenever the block is disabled, and during the part of each period outside the duty window.

The settings sit in a small write-only register bank that is reached through a select and data port. The running generator copies the settings into shadow registers only at period boundaries, so a write never produces a truncated or stretched period. A shared pause input freezes all counters, and the line then holds its present level.

Top module: `breath_pwm`

## Requirements
- R1: A PWM period lasts DIV+1 ticks. The period counter advances only on clock cycles where `tick` is high.
- R2: Each duty value stays in force for STEP+1 consecutive periods before it changes, and it changes only at a period boundary.
- R3: The duty value starts at the low bound and rises by one per hold expiry up to the high bound. It then falls by one per hold expiry to the low bound, and the cycle repeats. With low bound 1 and high bound 3 the per-period duties are 1,2,3,2,1,2.
- R4: During the first DUTY ticks of a period the output is at the active level, which is the inverse of the idle level. For the rest of the period it is at the idle level. A duty of DIV+1 or more keeps the output active for the whole period.
- R5: Control bit 1 selects the idle level (0 = low, 1 = high). While the block is disabled the output sits at the idle level.
- R6: Clearing the enable bit (control bit 0) returns the output to idle on the following cycle. A later enable restarts the ramp at the low bound, with a fresh period.
- R7: While `pause` is high the period counter, the hold counter and the duty value do not change, so the output holds its level.
- R8: Settings written during a run take effect only at the next period boundary. The period in progress keeps its old length.
- R9: After reset DIV=255, STEP=1, high bound=10, low bound=1, and enable and polarity are 0.
- R10: Register select values: 0 = DIV, 1 = STEP, 2 = high bound, 3 = low bound, 4 = control. Writes to selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 16 MHz enable strobe for the period counter |
| pause | input | 1 | Freeze request from the shared pause control |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output line |

## Verification
A corrupted period counter shows within one period as a wrong count of active ticks, or as a period of the wrong length. A wrong hold count or ramp direction shows as a wrong duty sequence within a few periods. Because of this, the bench counts active ticks per period over several consecutive periods and compares them against the expected duty series. A shadow load in the middle of a period is seen at the next expected boundary, where the output fails to return to the active level.

// File: rtl/breath_pkg.sv
package breath_pkg;

    localparam int unsigned BR_W  = 8;
    localparam int unsigned BR_AW = 3;

    typedef enum logic [BR_AW-1:0] {
        SEL_DIV  = 3'd0,
        SEL_STEP = 3'd1,
        SEL_TOP  = 3'd2,
        SEL_BOT  = 3'd3,
        SEL_CTRL = 3'd4
    } sel_e;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        logic [BR_W-1:0] div;
        logic [BR_W-1:0] step;
        logic [BR_W-1:0] top;
        logic [BR_W-1:0] bot;
    } shape_t;

    typedef struct packed {
        shape_t shape;
        logic   en;
        logic   pol;
    } cfg_t;

    typedef struct packed {
        logic [BR_W-1:0] level;
        ramp_dir_e       dir;
    } ramp_t;

    // One ramp move: rise to top, turn, fall to bot, turn.
    function automatic ramp_t ramp_next(input ramp_t cur,
                                        input logic [BR_W-1:0] bot,
                                        input logic [BR_W-1:0] top);
        ramp_t nxt;
        nxt = cur;
        if (cur.dir == RAMP_UP) begin
            if (cur.level < top) begin
                nxt.level = cur.level + 1'b1;
            end else begin
                nxt.dir = RAMP_DOWN;
                if (cur.level > bot) nxt.level = cur.level - 1'b1;
            end
        end else begin
            if (cur.level > bot) begin
                nxt.level = cur.level - 1'b1;
            end else begin
                nxt.dir = RAMP_UP;
                if (cur.level < top) nxt.level = cur.level + 1'b1;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/breath_regs.sv
module breath_regs
    import breath_pkg::*;
#(
    parameter logic [BR_W-1:0] RST_DIV  = 8'd255,
    parameter logic [BR_W-1:0] RST_STEP = 8'd1,
    parameter logic [BR_W-1:0] RST_TOP  = 8'd10,
    parameter logic [BR_W-1:0] RST_BOT  = 8'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [BR_AW-1:0] sel,
    input  logic [BR_W-1:0]  wdata,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.shape.div  <= RST_DIV;
            cfg.shape.step <= RST_STEP;
            cfg.shape.top  <= RST_TOP;
            cfg.shape.bot  <= RST_BOT;
            cfg.en         <= 1'b0;
            cfg.pol        <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_DIV:  cfg.shape.div  <= wdata;
                SEL_STEP: cfg.shape.step <= wdata;
                SEL_TOP:  cfg.shape.top  <= wdata;
                SEL_BOT:  cfg.shape.bot  <= wdata;
                SEL_CTRL: begin
                    cfg.en  <= wdata[0];
                    cfg.pol <= wdata[1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/breath_period.sv
module breath_period
    import breath_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            pause,
    input  cfg_t            cfg,
    output logic            run,
    output logic [BR_W-1:0] cnt,
    output shape_t          sh,
    output logic            start,
    output logic            wrap
);

    logic advance;

    assign start   = cfg.en && !run;
    assign advance = run && tick && !pause;
    assign wrap    = advance && (cnt == sh.div);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
            sh  <= '0;
        end else begin
            run <= cfg.en;
            if (start || wrap) begin
                cnt <= '0;
                sh  <= cfg.shape;
            end else if (advance) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/breath_ramp.sv
module breath_ramp
    import breath_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            wrap,
    input  logic [BR_W-1:0] start_level,
    input  shape_t          sh,
    output logic [BR_W-1:0] level
);

    ramp_t           st;
    logic [BR_W-1:0] hold;

    assign level = st.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '{level: '0, dir: RAMP_UP};
            hold <= '0;
        end else if (start) begin
            st   <= '{level: start_level, dir: RAMP_UP};
            hold <= '0;
        end else if (wrap) begin
            if (hold == sh.step) begin
                hold <= '0;
                st   <= ramp_next(st, sh.bot, sh.top);
            end else begin
                hold <= hold + 1'b1;
            end
        end
    end

endmodule

// File: rtl/breath_pwm.sv
module breath_pwm
    import breath_pkg::*;
#(
    parameter logic [BR_W-1:0] RST_DIV  = 8'd255,
    parameter logic [BR_W-1:0] RST_STEP = 8'd1,
    parameter logic [BR_W-1:0] RST_TOP  = 8'd10,
    parameter logic [BR_W-1:0] RST_BOT  = 8'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pause,
    input  logic             cfg_we,
    input  logic [BR_AW-1:0] cfg_sel,
    input  logic [BR_W-1:0]  cfg_wdata,
    output logic             pwm_out
);

    cfg_t            cfg_w;
    shape_t          sh_w;
    logic            run_w;
    logic [BR_W-1:0] cnt_w;
    logic [BR_W-1:0] duty_w;
    logic            start_w;
    logic            wrap_w;

    breath_regs #(
        .RST_DIV (RST_DIV),
        .RST_STEP(RST_STEP),
        .RST_TOP (RST_TOP),
        .RST_BOT (RST_BOT)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .sel  (cfg_sel),
        .wdata(cfg_wdata),
        .cfg  (cfg_w)
    );

    breath_period u_period (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pause(pause),
        .cfg  (cfg_w),
        .run  (run_w),
        .cnt  (cnt_w),
        .sh   (sh_w),
        .start(start_w),
        .wrap (wrap_w)
    );

    breath_ramp u_ramp (
        .clk        (clk),
        .rst        (rst),
        .start      (start_w),
        .wrap       (wrap_w),
        .start_level(cfg_w.shape.bot),
        .sh         (sh_w),
        .level      (duty_w)
    );

    always_comb begin
        pwm_out = cfg_w.pol;
        if (run_w && (cnt_w < duty_w)) pwm_out = ~cfg_w.pol;
    end

endmodule

// File: rtl/breath_pwm_chk.sv
module breath_pwm_chk
    import breath_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pause,
    input logic            pwm_out,
    input logic            pol,
    input logic            run,
    input logic [BR_W-1:0] cnt,
    input logic [BR_W-1:0] duty,
    input logic [BR_W-1:0] div_s,
    input logic [BR_W-1:0] bot_s
);

    a_r1_cnt_within_period: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div_s));

    a_r2_duty_moves_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (duty != $past(duty))) |-> (cnt == '0));

    a_r3_duty_unit_step: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (duty != $past(duty)))
            |-> ((duty == $past(duty) + 8'd1) || (duty == $past(duty) - 8'd1)));

    a_r5_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == pol));

    a_r6_restart_at_bottom: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> ((duty == bot_s) && (cnt == '0)));

    a_r7_pause_freezes: assert property (@(posedge clk) disable iff (rst)
        (run && pause) |=> ((cnt == $past(cnt)) && (duty == $past(duty))));

endmodule

bind breath_pwm breath_pwm_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pause  (pause),
    .pwm_out(pwm_out),
    .pol    (cfg_w.pol),
    .run    (run_w),
    .cnt    (cnt_w),
    .duty   (duty_w),
    .div_s  (sh_w.div),
    .bot_s  (sh_w.bot)
);

// File: tb/breath_pwm_test.sv
module breath_pwm_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       pause = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       pwm_out;
    logic       slow = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    breath_pwm uut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .pause    (pause),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .pwm_out  (pwm_out)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick = slow ? ~tick : 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        cfg_sel = sel; cfg_wdata = data; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic measure(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    // R10 map: 0 div, 1 step, 2 top, 3 bot, 4 ctrl {pol, en}
    task automatic start(input logic [7:0] d, input logic [7:0] s,
                         input logic [7:0] lo, input logic [7:0] hi, input logic p);
        wr(3'd4, {6'd0, p, 1'b0});
        wr(3'd0, d);
        wr(3'd1, s);
        wr(3'd3, lo);
        wr(3'd2, hi);
        wr(3'd4, {6'd0, p, 1'b1});
        @(negedge clk);
    endtask

    task automatic expect_series(input string tag, input int plen, input int n,
                                 input int exp[]);
        int h;
        for (int k = 0; k < n; k++) begin
            measure(plen, h);
            check(h == exp[k], tag, h, exp[k]);
        end
    endtask

    task automatic t_reset_defaults();
        int h;
        check(pwm_out == 1'b0, "R9 idle after reset", pwm_out, 0);
        wr(3'd4, 8'h01);
        @(negedge clk);
        measure(256, h); check(h == 1, "R9 default period 1", h, 1);
        measure(256, h); check(h == 1, "R9 default period 2 (step 1)", h, 1);
        measure(256, h); check(h == 2, "R9 default period 3", h, 2);
    endtask

    task automatic t_ramp();
        start(8'd3, 8'd0, 8'd1, 8'd3, 1'b0);
        expect_series("R3 ramp series", 4, 7, '{1, 2, 3, 2, 1, 2, 3});
    endtask

    task automatic t_hold();
        start(8'd3, 8'd2, 8'd1, 8'd2, 1'b0);
        expect_series("R2 hold series", 4, 9, '{1, 1, 1, 2, 2, 2, 1, 1, 1});
    endtask

    task automatic t_polarity();
        wr(3'd4, 8'h02);
        @(negedge clk);
        check(pwm_out == 1'b1, "R5 idle high when disabled", pwm_out, 1);
        start(8'd3, 8'd0, 8'd1, 8'd3, 1'b1);
        expect_series("R5 inverted series", 4, 3, '{3, 2, 1});
    endtask

    task automatic t_full_duty();
        start(8'd3, 8'd0, 8'd5, 8'd5, 1'b0);
        expect_series("R4 duty above period", 4, 2, '{4, 4});
        start(8'd4, 8'd0, 8'd2, 8'd2, 1'b0);
        expect_series("R4 partial duty", 5, 2, '{2, 2});
    endtask

    task automatic t_disable();
        int h;
        start(8'd3, 8'd0, 8'd1, 8'd3, 1'b0);
        measure(8, h);
        wr(3'd4, 8'h00);
        @(negedge clk);
        check(pwm_out == 1'b0, "R6 idle after disable", pwm_out, 0);
        measure(6, h);
        check(h == 0, "R6 stays idle", h, 0);
        wr(3'd4, 8'h01);
        @(negedge clk);
        expect_series("R6 restart at bottom", 4, 2, '{1, 2});
    endtask

    task automatic t_pause();
        int h;
        start(8'd3, 8'd0, 8'd1, 8'd3, 1'b0);
        pause = 1'b1;
        measure(10, h);
        check(h == 10, "R7 output held during pause", h, 10);
        pause = 1'b0;
        expect_series("R7 resume series", 4, 2, '{1, 2});
    endtask

    task automatic t_boundary_load();
        int h;
        start(8'd3, 8'd0, 8'd2, 8'd2, 1'b0);
        measure(2, h);
        check(h == 2, "R8 first half active", h, 2);
        check(pwm_out == 1'b0, "R8 cnt2 idle", pwm_out, 0);
        wr(3'd0, 8'd7);
        check(pwm_out == 1'b0, "R8 cnt3 idle", pwm_out, 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R8 old period length kept", pwm_out, 1);
        measure(8, h);
        check(h == 2, "R8 new period active ticks", h, 2);
        check(pwm_out == 1'b1, "R8 new period length", pwm_out, 1);
    endtask

    task automatic t_slow_tick();
        int h;
        slow = 1'b1;
        start(8'd3, 8'd0, 8'd1, 8'd3, 1'b0);
        measure(16, h);
        check(h == 6, "R1 period follows tick", h, 6);
        slow = 1'b0;
    endtask

    task automatic t_unused_sel();
        int h;
        wr(3'd4, 8'h00);
        @(negedge clk);
        wr(3'd7, 8'h03);
        wr(3'd5, 8'h03);
        measure(6, h);
        check(h == 0, "R10 unused selects ignored", h, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_defaults();
        t_ramp();
        t_hold();
        t_polarity();
        t_full_duty();
        t_disable();
        t_pause();
        t_boundary_load();
        t_slow_tick();
        t_unused_sel();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule